// File: doc/BRIEF.md
# Address Status Bus Multiplexer

This block drives the upper address pins, the high-byte-enable pin and the shared address/data lanes of a 16-bit processor bus that carries a 20-bit address. Each bus transfer runs through four clock states, T1 to T4. During T1 the four upper pins carry the top address nibble, and the enable pin is active low for word or odd-byte transfers. During T2 to T4 the same five pins carry a status code instead: the segment register that formed the address, the interrupt-enable flag and a spare bit. On I/O transfers the upper address nibble is forced to zero, and the 16-bit port number appears on the low lanes exactly as a memory address would.

The block also steers bytes between a 16-bit internal data word and the even and odd data lanes. On a write, a byte at an even address leaves on the low lane and a byte at an odd address leaves on the high lane. On a read, the addressed lane is returned in the low byte of the internal word. A one-cycle start strobe latches the whole request. The request stays frozen for the rest of the transfer, and a new transfer may start in the last state of the previous one.

Top module: `asb_mux_top`

## Requirements
- R1: A start strobe sampled while `phase_o` is idle (code 0) makes `phase_o` read 1, 2, 3 and 4 (T1 to T4) on the next four cycles and then return to 0.
- R2: A start strobe sampled in T1, T2 or T3 has no effect. A strobe sampled in T4 makes the next cycle T1 of a new transfer.
- R3: In T1, `ad_o` carries address bits 15..0. `hi_pins_o` carries address bits 19..16 on memory transfers and reads zero on I/O transfers.
- R4: In T1, `bhe_pin_o` is 0 for a word transfer or an odd address (bit 0 = 1), and 1 for a byte transfer at an even address.
- R5: In T2, T3 and T4, `hi_pins_o[1:0]` carries the segment code (00 extra, 01 stack, 10 code or none, 11 data). `hi_pins_o[2]` carries the interrupt-enable flag, `hi_pins_o[3]` is 0 and `bhe_pin_o` carries the spare bit. These pins hold steady across the three states.
- R6: In T2 to T4 of a write, `ad_o` carries the whole data word for a word transfer. A byte at an even address goes on `ad_o[7:0]` with `ad_o[15:8]` = 0, and a byte at an odd address goes on `ad_o[15:8]` with `ad_o[7:0]` = 0. On reads `ad_o` is 0 in T2 to T4.
- R7: In T4 of a read, `rd_vld_o` is 1 and `rd_word_o` holds the lanes sampled at the end of T3. That is the whole word for a word read, `{8'h00, lanes[15:8]}` for an odd byte, and `{8'h00, lanes[7:0]}` for an even byte. `rd_vld_o` is 0 at all other times.
- R8: When idle, and after reset, `hi_pins_o` = 0, `bhe_pin_o` = 1, `ad_o` = 0 and `rd_vld_o` = 0.
- R9: The request inputs are captured with the accepted strobe. Changing them later in the transfer does not change any pin of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| addr_i | input | 20 | Transfer address |
| io_i | input | 1 | 1 = I/O transfer, 0 = memory |
| word_i | input | 1 | 1 = word transfer, 0 = byte |
| write_i | input | 1 | 1 = write, 0 = read |
| seg_i | input | 2 | Segment code of the address |
| ie_i | input | 1 | Interrupt-enable flag |
| spare_i | input | 1 | Spare status bit |
| wdata_i | input | 16 | Internal write word (byte in bits 7..0) |
| bus_din_i | input | 16 | Data lanes seen on reads |
| hi_pins_o | output | 4 | Address 19..16 in T1, status in T2 to T4 |
| bhe_pin_o | output | 1 | High-byte enable (low active) in T1, spare status later |
| ad_o | output | 16 | Low address in T1, steered write lanes later |
| phase_o | output | 3 | 0 idle, 1 to 4 for T1 to T4 |
| rd_word_o | output | 16 | Steered read word |
| rd_vld_o | output | 1 | Read word valid (T4 of a read) |

## Verification
Two things can fall in the same cycle: the T4 of one transfer, which shows its status and its read result, and the acceptance of the strobe that opens the next transfer. The bench provokes this by issuing back-to-back requests whose segment, flag, direction and lanes all differ. The scoreboard then requires a full, correct T4 item followed at once by a T1 item carrying the new address and enable, with no idle cycle between them. Strobes that are held through T1, together with scrambled request inputs, are judged by the same queue: an extra or altered state item is reported.

// File: rtl/asb_pkg.sv
package asb_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_T4   = 3'd4
   } phase_t;

   localparam logic [1:0] SEG_EXTRA = 2'b00;
   localparam logic [1:0] SEG_STACK = 2'b01;
   localparam logic [1:0] SEG_CODE  = 2'b10;
   localparam logic [1:0] SEG_DATA  = 2'b11;

   typedef struct packed {
      logic       io;
      logic       word;
      logic       write;
      logic       ie;
      logic       spare;
      logic [1:0] seg;
   } req_ctl_t;
endpackage

// File: rtl/asb_tseq.sv
module asb_tseq
   import asb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   output phase_t phase_o,
   output logic   accept_o
);
   timeunit 1ns;
   timeprecision 1ps;

   phase_t ph_q, ph_d;

   always_comb begin
      accept_o = start_i && ((ph_q == PH_IDLE) || (ph_q == PH_T4));
      case (ph_q)
         PH_IDLE: ph_d = accept_o ? PH_T1 : PH_IDLE;
         PH_T1:   ph_d = PH_T2;
         PH_T2:   ph_d = PH_T3;
         PH_T3:   ph_d = PH_T4;
         PH_T4:   ph_d = accept_o ? PH_T1 : PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase_o = ph_q;

   // R1
   t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_T1) |=> (ph_q == PH_T2));
   // R1
   t3_to_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_T3) |=> (ph_q == PH_T4));
   // R1
   idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ph_q == PH_IDLE) |=> (ph_q == PH_T1));
   // R2
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (ph_q == PH_T1 || ph_q == PH_T2)) |=> (ph_q != PH_T1));
endmodule

// File: rtl/asb_pinmux.sv
module asb_pinmux
   import asb_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase_i,
   input  req_ctl_t          ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] lane_data_i,
   output logic [HI_W-1:0]   hi_pins_o,
   output logic              bhe_pin_o,
   output logic [DATA_W-1:0] ad_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [HI_W-1:0] status_w;
   logic [HI_W-1:0] hi_addr_w;
   logic            in_status;

   for (genvar b = 0; b < HI_W; b++) begin : g_stat
      if (b < 2) begin : g_seg
         assign status_w[b] = ctl_i.seg[b];
      end else if (b == 2) begin : g_ie
         assign status_w[b] = ctl_i.ie;
      end else begin : g_zero
         assign status_w[b] = 1'b0;
      end
   end

   assign hi_addr_w = ctl_i.io ? '0 : addr_i[ADDR_W-1:DATA_W];
   assign in_status = (phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_T4);

   always_comb begin
      hi_pins_o = '0;
      bhe_pin_o = 1'b1;
      ad_o      = '0;
      if (phase_i == PH_T1) begin
         hi_pins_o = hi_addr_w;
         bhe_pin_o = !(ctl_i.word || addr_i[0]);
         ad_o      = addr_i[DATA_W-1:0];
      end else if (in_status) begin
         hi_pins_o = status_w;
         bhe_pin_o = ctl_i.spare;
         ad_o      = lane_data_i;
      end
   end

   // R5
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_i == PH_T3) || (phase_i == PH_T4)) |->
         ($stable(hi_pins_o) && $stable(bhe_pin_o)));
   // R8
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_IDLE) |-> (hi_pins_o == '0 && bhe_pin_o && ad_o == '0));
endmodule

// File: rtl/asb_lanes.sv
module asb_lanes
   import asb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int NLANE = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase_i,
   input  req_ctl_t          ctl_i,
   input  logic              a0_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] lane_data_o,
   output logic [DATA_W-1:0] rd_word_o,
   output logic              rd_vld_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DATA_W-1:0] wr_lanes;
   logic [LANE_W-1:0] rd_byte;
   logic [DATA_W-1:0] rd_next, rd_q;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign wr_lanes[l*LANE_W +: LANE_W] =
         ctl_i.word ? wdata_i[l*LANE_W +: LANE_W] :
         (a0_i == 1'(l)) ? wdata_i[LANE_W-1:0] : '0;
   end

   assign rd_byte     = a0_i ? din_i[DATA_W-1:LANE_W] : din_i[LANE_W-1:0];
   assign rd_next     = ctl_i.word ? din_i : {{(DATA_W-LANE_W){1'b0}}, rd_byte};
   assign lane_data_o = ctl_i.write ? wr_lanes : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   rd_q <= '0;
      else if (phase_i == PH_T3 && !ctl_i.write)    rd_q <= rd_next;
   end

   assign rd_word_o = rd_q;
   assign rd_vld_o  = (phase_i == PH_T4) && !ctl_i.write;

   // R6
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.write && !ctl_i.word && phase_i == PH_T2) |->
         (a0_i ? (lane_data_o[LANE_W-1:0] == '0) : (lane_data_o[DATA_W-1:LANE_W] == '0)));
   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_T4) |=> $stable(rd_word_o));
endmodule

// File: rtl/asb_mux_top.sv
module asb_mux_top
   import asb_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              io_i,
   input  logic              word_i,
   input  logic              write_i,
   input  logic [1:0]        seg_i,
   input  logic              ie_i,
   input  logic              spare_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] bus_din_i,
   output logic [HI_W-1:0]   hi_pins_o,
   output logic              bhe_pin_o,
   output logic [DATA_W-1:0] ad_o,
   output logic [2:0]        phase_o,
   output logic [DATA_W-1:0] rd_word_o,
   output logic              rd_vld_o
);
   timeunit 1ns;
   timeprecision 1ps;

   initial begin
      assert (HI_W >= 4) else $error("upper pin group too narrow for status");
      assert (DATA_W == 2 * LANE_W) else $error("bus must have exactly two lanes");
   end

   phase_t            phase;
   logic              accept;
   req_ctl_t          ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, lane_data;

   asb_tseq u_tseq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .phase_o(phase), .accept_o(accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         ctl_q   <= '{io: io_i, word: word_i, write: write_i, ie: ie_i,
                      spare: spare_i, seg: seg_i};
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
      end
   end

   asb_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .phase_i(phase), .ctl_i(ctl_q),
      .a0_i(addr_q[0]), .wdata_i(wdata_q), .din_i(bus_din_i),
      .lane_data_o(lane_data), .rd_word_o(rd_word_o), .rd_vld_o(rd_vld_o)
   );

   asb_pinmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pinmux (
      .clk(clk), .rst_n(rst_n), .phase_i(phase), .ctl_i(ctl_q),
      .addr_i(addr_q), .lane_data_i(lane_data),
      .hi_pins_o(hi_pins_o), .bhe_pin_o(bhe_pin_o), .ad_o(ad_o)
   );

   assign phase_o = phase;

   // R3
   io_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && io_i) |=> (hi_pins_o == '0));
   // R4
   word_bhe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && word_i) |=> !bhe_pin_o);
endmodule

// File: tb/sim_asb_mux_top.sv
module sim_asb_mux_top;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct {
      logic [2:0]  ph;
      logic [3:0]  hi;
      logic        bhe;
      logic [15:0] ad;
      logic        rdv;
      logic [15:0] rdw;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [19:0] addr_i = '0;
   logic io_i = 0, word_i = 0, write_i = 0, ie_i = 0, spare_i = 0;
   logic [1:0] seg_i = '0;
   logic [15:0] wdata_i = '0, bus_din_i = '0;
   logic [3:0] hi_pins_o;
   logic bhe_pin_o, rd_vld_o;
   logic [15:0] ad_o, rd_word_o;
   logic [2:0] phase_o;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   asb_mux_top u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .io_i(io_i), .word_i(word_i), .write_i(write_i), .seg_i(seg_i),
      .ie_i(ie_i), .spare_i(spare_i), .wdata_i(wdata_i), .bus_din_i(bus_din_i),
      .hi_pins_o(hi_pins_o), .bhe_pin_o(bhe_pin_o), .ad_o(ad_o),
      .phase_o(phase_o), .rd_word_o(rd_word_o), .rd_vld_o(rd_vld_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   // driver: pushes the four expected state items, then drives the request
   task automatic launch(input logic io, word, wr, input logic [1:0] seg,
                         input logic ie, sp, input logic [19:0] a,
                         input logic [15:0] wd, din, input bit b2b, input bit poke);
      exp_t e;
      logic [15:0] lanes, rdw;
      if (!b2b) @(negedge clk);
      @(negedge clk);
      // R6 expected lanes
      lanes = !wr ? 16'h0 : word ? wd : a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
      // R7 expected read word
      rdw = word ? din : a[0] ? {8'h00, din[15:8]} : {8'h00, din[7:0]};
      // R3, R4: T1
      e.ph = 3'd1; e.hi = io ? 4'h0 : a[19:16]; e.bhe = !(word || a[0]);
      e.ad = a[15:0]; e.rdv = 0; e.rdw = '0;
      sb.push_back(e);
      // R5: T2..T4
      for (int k = 2; k <= 4; k++) begin
         e.ph = 3'(k); e.hi = {1'b0, ie, seg}; e.bhe = sp; e.ad = lanes;
         e.rdv = (k == 4) && !wr; e.rdw = rdw;
         sb.push_back(e);
      end
      start_i = 1; addr_i = a; io_i = io; word_i = word; write_i = wr;
      seg_i = seg; ie_i = ie; spare_i = sp; wdata_i = wd; bus_din_i = din;
      @(negedge clk);
      // R9: scramble request inputs after capture; R2: optionally hold strobe through T1
      start_i = poke; addr_i = ~a; io_i = ~io; word_i = ~word; write_i = ~wr;
      seg_i = ~seg; ie_i = ~ie; spare_i = ~sp; wdata_i = ~wd;
      @(negedge clk);
      start_i = 0;
      @(negedge clk);
   endtask

   // monitor: pops and compares one item per active state
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk); #2;
         if (phase_o != 3'd0) begin
            if (sb.size() == 0) begin
               chk(0, "R2 unexpected state", 32'(phase_o), 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(phase_o == e.ph, "R1 phase", 32'(phase_o), 32'(e.ph));
               chk(hi_pins_o == e.hi, (e.ph == 1) ? "R3 hi pins T1" : "R5 status pins",
                   32'(hi_pins_o), 32'(e.hi));
               chk(bhe_pin_o == e.bhe, (e.ph == 1) ? "R4 bhe T1" : "R5 spare bit",
                   32'(bhe_pin_o), 32'(e.bhe));
               chk(ad_o == e.ad, (e.ph == 1) ? "R3 low address" : "R6 lanes R9",
                   32'(ad_o), 32'(e.ad));
               chk(rd_vld_o == e.rdv, "R7 rd_vld", 32'(rd_vld_o), 32'(e.rdv));
               if (e.rdv)
                  chk(rd_word_o == e.rdw, "R7 read word", 32'(rd_word_o), 32'(e.rdw));
            end
         end else if (sb.size() == 0) begin
            chk(hi_pins_o == 0 && bhe_pin_o && ad_o == 0 && !rd_vld_o, "R8 idle pins",
                {11'h0, rd_vld_o, ad_o, bhe_pin_o, hi_pins_o}, 32'h0000_0010);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         chk(0, "watchdog", 32'(cyc), 32'd0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(hi_pins_o == 0 && bhe_pin_o == 1 && ad_o == 0 && !rd_vld_o && phase_o == 0 && rd_word_o == 0,
          "R8 reset", {rd_word_o, 3'b0, phase_o, ad_o[3:0], rd_vld_o, bhe_pin_o, hi_pins_o},
          32'h0000_0010);
      rst_n = 1;
      // R3 R4 R5 R6 R7: every segment, flag, space, address parity and direction
      for (int s = 0; s < 4; s++)
         for (int f = 0; f < 2; f++)
            for (int io = 0; io < 2; io++)
               for (int p = 0; p < 2; p++) begin
                  logic [19:0] a;
                  a = {4'(s * 3 + f + 5), 15'(s * 4099 + io * 77 + f * 313), 1'(p)};
                  launch(1'(io), 1'b0, 1'(p ^ f), 2'(s), 1'(f), 1'(s[0] ^ p),
                         a, 16'(16'hA55A + s * 16'h1111 + p), 16'(16'hC3E1 ^ (s << 4) ^ p),
                         0, 0);
               end
      // word transfers, read and write
      launch(0, 1, 1, 2'b11, 1, 0, 20'hF_1234, 16'hBEEF, 16'h0, 0, 0);
      launch(1, 1, 0, 2'b10, 0, 1, 20'h7_8001, 16'h0, 16'h5AA5, 0, 0);
      // R2: strobe held through T1 is ignored
      launch(0, 0, 0, 2'b01, 1, 1, 20'h9_0003, 16'h0, 16'h8142, 0, 1);
      // R2: back-to-back start in T4, all fields differ
      launch(0, 0, 0, 2'b00, 0, 0, 20'hA_0005, 16'h0, 16'h12FE, 0, 0);
      launch(1, 1, 1, 2'b11, 1, 1, 20'h3_0010, 16'h6C39, 16'h0, 1, 0);
      launch(0, 0, 1, 2'b10, 0, 1, 20'hE_FFFF, 16'h00D7, 16'h0, 1, 0);
      launch(0, 1, 0, 2'b01, 1, 0, 20'h5_4320, 16'h0, 16'hF00D, 1, 0);
      repeat (8) @(negedge clk);
      chk(sb.size() == 0, "R1 all states seen", 32'(sb.size()), 32'd0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule